// File: doc/BRIEF.md
# Broadcast Gateway Hub Controller

This block is the digital controller that sits between one system's wired on-chip network and a shared broadcast medium shared by several nearby systems. Flits from the local router go out on the medium unchanged, so each packet keeps its destination system ID. Flits heard on the medium are filtered by that ID. Only packets for this system are passed into the wired network, and the rest are discarded silently.

The block also handles neighbour discovery. A programmable timer makes the hub broadcast a one-flit beacon that names its own system. A beacon from a system that has not been seen before is recorded in a 256-entry presence bitmap and answered with a one-flit exchange frame that carries this hub's resource word. An exchange frame addressed to this hub records its sender and reports the sender's resource word. If a packet is addressed to another system that is not in the bitmap, it is dropped and an error pulse is raised.

Flit layout, 32 bits. Bits [31:30] give the flit kind: 10 is a packet head, 00 is a body flit, 01 is the packet tail, and 11 is a control frame. A head carries the destination system in [29:22], the destination PE in [21:15], the source system in [14:7] and the source PE in [6:0]. A control frame carries the control kind in [29:28] (00 is a beacon, 01 is an exchange), the sender system in [27:20], the target system in [19:12] and a 12-bit resource word in [11:0]. A beacon sends 0 as its target.

Top module: `hub_gateway`

## Requirements
- R1: While reset is held and in the cycle after it is released, these outputs are 0: air_tx_valid, noc_out_valid, unknown_dst_err, peer_learn_valid and query_present. tx_in_ready is 1 and every bitmap entry is clear.
- R2: A router flit accepted at a clock edge (tx_in_valid and tx_in_ready both 1) appears unchanged on air_tx_flit, with air_tx_valid set, for the one cycle after that edge.
- R3: Beacon timing and format. The period P equals beacon_period, or DEF_PERIOD when beacon_period is 0. After reset, and after each beacon request, a new beacon request is raised every P cycles. The beacon flit is {11, 00, own ID, 8'h00, own_res}.
- R4: A beacon or exchange frame is never sent while an outgoing packet is open, which is from an accepted head to its accepted tail. While no packet is open and a control frame is pending, tx_in_ready is 0. A pending beacon goes out before a pending exchange.
- R5: A head whose destination system equals own_sys_id is forwarded to noc_out one cycle later. So are the body and tail flits that follow it, up to and including the tail.
- R6: A head for another system, and the body and tail flits that follow it, never reach noc_out.
- R7: A head for another system that is not marked in the bitmap raises unknown_dst_err for one cycle, one cycle after the head arrives. A head for a marked system raises no error.
- R8: A beacon from a system other than this one that is not marked in the bitmap has two effects. It marks the sender, and it makes the hub send {11, 01, own ID, sender, own_res}.
- R9: A beacon from a marked system, or one that carries this hub's own ID, changes no state and causes no reply.
- R10: An exchange frame whose target is own_sys_id, from another system, marks the sender. It also pulses peer_learn_valid one cycle later, with peer_learn_id set to the sender and peer_learn_res set to the resource word. An exchange frame with any other target is ignored.
- R11: Only one exchange reply can wait at a time. A new beacon that arrives while a reply is still waiting leaves its sender unmarked, so the sender is picked up at its next beacon.
- R12: query_present shows, one cycle later, the bitmap entry for query_id as it stood before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_sys_id | input | 8 | This system's ID |
| own_res | input | 12 | Resource word sent in beacons and exchange frames |
| beacon_period | input | CNT_W | Beacon interval in cycles; 0 selects DEF_PERIOD |
| tx_in_valid | input | 1 | Router offers a flit |
| tx_in_flit | input | 32 | Flit from router |
| tx_in_ready | output | 1 | Hub takes the offered flit this cycle |
| air_tx_valid | output | 1 | Flit broadcast on the medium |
| air_tx_flit | output | 32 | Broadcast flit |
| air_rx_valid | input | 1 | Flit heard on the medium |
| air_rx_flit | input | 32 | Heard flit |
| noc_out_valid | output | 1 | Flit forwarded into the wired network |
| noc_out_flit | output | 32 | Forwarded flit |
| unknown_dst_err | output | 1 | Pulse: dropped head for an unknown system |
| peer_learn_valid | output | 1 | Pulse: exchange frame received |
| peer_learn_id | output | 8 | Sender of the exchange frame |
| peer_learn_res | output | 12 | Sender's resource word |
| query_id | input | 8 | Bitmap entry to read |
| query_present | output | 1 | Registered value of that entry |

## Verification
The bench builds the hub with DEF_PERIOD = 40 and CNT_W = 8, so that many beacon intervals fit into a short run. Early in the run it also switches beacon_period to 25, which exercises the programmed path as well as the default one. With periods this short, beacon requests keep landing inside open outgoing packets, which tests deferral and the ordering of beacon before exchange reply. A random mix of heard flits over a small pool of system IDs reaches the cases of a full reply slot, a beacon already known, a beacon carrying this hub's own ID, and a destination not yet known.

// File: rtl/hub_pkg.sv
package hub_pkg;
  localparam int FLIT_W = 32;
  localparam int SYS_W  = 8;
  localparam int RES_W  = 12;
  localparam int NSYS   = 1 << SYS_W;

  localparam logic [1:0] FT_BODY = 2'b00;
  localparam logic [1:0] FT_TAIL = 2'b01;
  localparam logic [1:0] FT_HEAD = 2'b10;
  localparam logic [1:0] FT_CTRL = 2'b11;

  localparam logic [1:0] CK_BEACON = 2'b00;
  localparam logic [1:0] CK_XCHG   = 2'b01;

  function automatic logic [1:0] f_type(input logic [FLIT_W-1:0] f);
    return f[31:30];
  endfunction

  function automatic logic [SYS_W-1:0] f_dst_sys(input logic [FLIT_W-1:0] f);
    return f[29:22];
  endfunction

  function automatic logic [1:0] f_ckind(input logic [FLIT_W-1:0] f);
    return f[29:28];
  endfunction

  function automatic logic [SYS_W-1:0] f_csnd(input logic [FLIT_W-1:0] f);
    return f[27:20];
  endfunction

  function automatic logic [SYS_W-1:0] f_ctgt(input logic [FLIT_W-1:0] f);
    return f[19:12];
  endfunction

  function automatic logic [RES_W-1:0] f_cres(input logic [FLIT_W-1:0] f);
    return f[11:0];
  endfunction

  function automatic logic [FLIT_W-1:0] mk_ctrl(input logic [1:0] kind,
                                                input logic [SYS_W-1:0] snd,
                                                input logic [SYS_W-1:0] tgt,
                                                input logic [RES_W-1:0] res);
    return {FT_CTRL, kind, snd, tgt, res};
  endfunction
endpackage

// File: rtl/hub_beacon_timer.sv
module hub_beacon_timer #(
  parameter int CNT_W      = 16,
  parameter int DEF_PERIOD = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] eff;

  always_comb begin
    eff  = (period == '0) ? CNT_W'(DEF_PERIOD) : period;
    tick = (cnt >= eff - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (tick) cnt <= '0;
    else cnt <= cnt + CNT_W'(1);
  end

  // R3: once the count wraps, the next edge does not request a beacon unless the period is 1
  a_r3_wrap_restarts: assert property (@(posedge clk) disable iff (rst)
    tick && eff > CNT_W'(1) |=> !tick || $changed(period));
endmodule

// File: rtl/hub_presence_map.sv
module hub_presence_map #(
  parameter int IDW = 8,
  localparam int N  = 1 << IDW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           set_en,
  input  logic [IDW-1:0] set_id,
  input  logic [IDW-1:0] rd_a,
  output logic           hit_a,
  input  logic [IDW-1:0] rd_b,
  output logic           hit_b
);
  logic [N-1:0] bits;

  assign hit_a = bits[rd_a];
  assign hit_b = bits[rd_b];

  always_ff @(posedge clk) begin
    if (rst) bits <= '0;
    else if (set_en) bits[set_id] <= 1'b1;
  end

  // R9: a system already recorded is never recorded again (no repeated handshake)
  a_r9_only_new_marked: assert property (@(posedge clk) disable iff (rst)
    set_en |-> !bits[set_id]);
endmodule

// File: rtl/hub_rx_filter.sv
module hub_rx_filter
  import hub_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SYS_W-1:0]  own_id,
  input  logic              rx_valid,
  input  logic [FLIT_W-1:0] rx_flit,
  input  logic              known,
  input  logic              slot_busy,
  output logic [SYS_W-1:0]  lookup_id,
  output logic              set_en,
  output logic [SYS_W-1:0]  set_id,
  output logic              req_en,
  output logic [SYS_W-1:0]  req_id,
  output logic              fwd_valid,
  output logic [FLIT_W-1:0] fwd_flit,
  output logic              err_pulse,
  output logic              learn_valid,
  output logic [SYS_W-1:0]  learn_id,
  output logic [RES_W-1:0]  learn_res
);
  logic [1:0]       ty;
  logic             is_ctrl;
  logic [SYS_W-1:0] snd;
  logic             new_bcn;
  logic             xchg_me;
  logic             fwd_on;

  always_comb begin
    ty        = f_type(rx_flit);
    is_ctrl   = rx_valid && (ty == FT_CTRL);
    snd       = f_csnd(rx_flit);
    lookup_id = is_ctrl ? snd : f_dst_sys(rx_flit);
    new_bcn   = is_ctrl && (f_ckind(rx_flit) == CK_BEACON) && (snd != own_id)
                && !known && !slot_busy;
    xchg_me   = is_ctrl && (f_ckind(rx_flit) == CK_XCHG) && (f_ctgt(rx_flit) == own_id)
                && (snd != own_id);
    set_en    = new_bcn || (xchg_me && !known);
    set_id    = snd;
    req_en    = new_bcn;
    req_id    = snd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_on      <= 1'b0;
      fwd_valid   <= 1'b0;
      fwd_flit    <= '0;
      err_pulse   <= 1'b0;
      learn_valid <= 1'b0;
      learn_id    <= '0;
      learn_res   <= '0;
    end else begin
      fwd_valid   <= 1'b0;
      err_pulse   <= 1'b0;
      learn_valid <= 1'b0;
      if (rx_valid && !is_ctrl) begin
        unique case (ty)
          FT_HEAD: begin
            if (f_dst_sys(rx_flit) == own_id) begin
              fwd_on    <= 1'b1;
              fwd_valid <= 1'b1;
              fwd_flit  <= rx_flit;
            end else begin
              fwd_on    <= 1'b0;
              err_pulse <= !known;
            end
          end
          FT_BODY: begin
            if (fwd_on) begin
              fwd_valid <= 1'b1;
              fwd_flit  <= rx_flit;
            end
          end
          default: begin
            if (fwd_on) begin
              fwd_valid <= 1'b1;
              fwd_flit  <= rx_flit;
            end
            fwd_on <= 1'b0;
          end
        endcase
      end
      if (xchg_me) begin
        learn_valid <= 1'b1;
        learn_id    <= snd;
        learn_res   <= f_cres(rx_flit);
      end
    end
  end

  // R5: a forwarded head always names this system
  a_r5_fwd_head_own: assert property (@(posedge clk) disable iff (rst)
    fwd_valid && (f_type(fwd_flit) == FT_HEAD) |-> f_dst_sys(fwd_flit) == $past(own_id));
  // R7: a head that raises the error was dropped, not forwarded
  a_r7_err_not_fwd: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> !fwd_valid);
  // R11: no reply is requested while the slot is occupied
  a_r11_slot_free: assert property (@(posedge clk) disable iff (rst)
    req_en |-> !slot_busy);
endmodule

// File: rtl/hub_tx_arb.sv
module hub_tx_arb
  import hub_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SYS_W-1:0]  own_id,
  input  logic [RES_W-1:0]  own_res,
  input  logic              tx_valid,
  input  logic [FLIT_W-1:0] tx_flit,
  output logic              tx_ready,
  input  logic              beacon_tick,
  input  logic              reply_req,
  input  logic [SYS_W-1:0]  reply_id,
  output logic              reply_busy,
  output logic              air_valid,
  output logic [FLIT_W-1:0] air_flit
);
  logic             in_pkt;
  logic             bcn_pend;
  logic             rep_pend;
  logic [SYS_W-1:0] rep_id;
  logic             acc;

  always_comb begin
    tx_ready   = in_pkt || (!bcn_pend && !rep_pend);
    acc        = tx_valid && tx_ready;
    reply_busy = rep_pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt    <= 1'b0;
      bcn_pend  <= 1'b0;
      rep_pend  <= 1'b0;
      rep_id    <= '0;
      air_valid <= 1'b0;
      air_flit  <= '0;
    end else begin
      air_valid <= 1'b0;
      if (acc) begin
        air_valid <= 1'b1;
        air_flit  <= tx_flit;
        if (f_type(tx_flit) == FT_HEAD) in_pkt <= 1'b1;
        else if (f_type(tx_flit) == FT_TAIL) in_pkt <= 1'b0;
      end else if (!in_pkt && bcn_pend) begin
        air_valid <= 1'b1;
        air_flit  <= mk_ctrl(CK_BEACON, own_id, '0, own_res);
        bcn_pend  <= 1'b0;
      end else if (!in_pkt && rep_pend) begin
        air_valid <= 1'b1;
        air_flit  <= mk_ctrl(CK_XCHG, own_id, rep_id, own_res);
        rep_pend  <= 1'b0;
      end
      if (beacon_tick) bcn_pend <= 1'b1;
      if (reply_req) begin
        rep_pend <= 1'b1;
        rep_id   <= reply_id;
      end
    end
  end

  // R4: no control frame leaves while an outgoing packet is open
  a_r4_defer_ctrl: assert property (@(posedge clk) disable iff (rst)
    $past(in_pkt) && air_valid |-> f_type(air_flit) != FT_CTRL);
  // R4: a waiting beacon always goes out ahead of an exchange reply
  a_r4_beacon_first: assert property (@(posedge clk) disable iff (rst)
    air_valid && (f_type(air_flit) == FT_CTRL) && (f_ckind(air_flit) == CK_XCHG)
    |-> !$past(bcn_pend));
endmodule

// File: rtl/hub_gateway.sv
module hub_gateway
  import hub_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DEF_PERIOD = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SYS_W-1:0]  own_sys_id,
  input  logic [RES_W-1:0]  own_res,
  input  logic [CNT_W-1:0]  beacon_period,
  input  logic              tx_in_valid,
  input  logic [FLIT_W-1:0] tx_in_flit,
  output logic              tx_in_ready,
  output logic              air_tx_valid,
  output logic [FLIT_W-1:0] air_tx_flit,
  input  logic              air_rx_valid,
  input  logic [FLIT_W-1:0] air_rx_flit,
  output logic              noc_out_valid,
  output logic [FLIT_W-1:0] noc_out_flit,
  output logic              unknown_dst_err,
  output logic              peer_learn_valid,
  output logic [SYS_W-1:0]  peer_learn_id,
  output logic [RES_W-1:0]  peer_learn_res,
  input  logic [SYS_W-1:0]  query_id,
  output logic              query_present
);
  logic             tick;
  logic             set_en, req_en, busy, hit_a, hit_b;
  logic [SYS_W-1:0] set_id, req_id, lookup_id;

  hub_beacon_timer #(.CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD)) u_timer (
    .clk(clk), .rst(rst), .period(beacon_period), .tick(tick));

  hub_presence_map #(.IDW(SYS_W)) u_map (
    .clk(clk), .rst(rst), .set_en(set_en), .set_id(set_id),
    .rd_a(lookup_id), .hit_a(hit_a), .rd_b(query_id), .hit_b(hit_b));

  hub_rx_filter u_rx (
    .clk(clk), .rst(rst), .own_id(own_sys_id),
    .rx_valid(air_rx_valid), .rx_flit(air_rx_flit),
    .known(hit_a), .slot_busy(busy), .lookup_id(lookup_id),
    .set_en(set_en), .set_id(set_id), .req_en(req_en), .req_id(req_id),
    .fwd_valid(noc_out_valid), .fwd_flit(noc_out_flit), .err_pulse(unknown_dst_err),
    .learn_valid(peer_learn_valid), .learn_id(peer_learn_id), .learn_res(peer_learn_res));

  hub_tx_arb u_tx (
    .clk(clk), .rst(rst), .own_id(own_sys_id), .own_res(own_res),
    .tx_valid(tx_in_valid), .tx_flit(tx_in_flit), .tx_ready(tx_in_ready),
    .beacon_tick(tick), .reply_req(req_en), .reply_id(req_id), .reply_busy(busy),
    .air_valid(air_tx_valid), .air_flit(air_tx_flit));

  always_ff @(posedge clk) begin
    if (rst) query_present <= 1'b0;
    else query_present <= hit_b;
  end

  // R1: the cycle after reset release shows an idle hub
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !air_tx_valid && !noc_out_valid && !unknown_dst_err && !query_present);
endmodule

// File: tb/hub_gateway_test.sv
`timescale 1ns/1ps
module hub_gateway_test;
  localparam int CW = 8;
  localparam int DP = 40;
  localparam logic [7:0] OWN = 8'h05;
  localparam logic [11:0] RES = 12'hA5C;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0]    own_sys_id = OWN;
  logic [11:0]   own_res = RES;
  logic [CW-1:0] beacon_period = '0;
  logic tx_in_valid = 1'b0;  logic [31:0] tx_in_flit = '0;  logic tx_in_ready;
  logic air_tx_valid;        logic [31:0] air_tx_flit;
  logic air_rx_valid = 1'b0; logic [31:0] air_rx_flit = '0;
  logic noc_out_valid;       logic [31:0] noc_out_flit;
  logic unknown_dst_err, peer_learn_valid;
  logic [7:0] peer_learn_id; logic [11:0] peer_learn_res;
  logic [7:0] query_id = '0; logic query_present;

  int checks = 0, errors = 0, cycles = 0;

  always #2.5 clk = ~clk;

  hub_gateway #(.CNT_W(CW), .DEF_PERIOD(DP)) uut (.*);

  // behavioural reference model
  int m_cnt; bit m_bp, m_rp, m_inpkt, m_fwd; bit [7:0] m_rid;
  bit m_air_v, m_noc_v, m_err, m_lv, m_q; bit [31:0] m_air_f, m_noc_f;
  bit [7:0] m_lid; bit [11:0] m_lres; bit m_map [256];

  always @(posedge clk) begin
    int eff; bit tick, rdy, rq, mk, kn; bit [7:0] rq_id, mk_id, snd, dsys;
    bit [1:0] ty;
    if (rst) begin
      m_cnt = 0; m_bp = 0; m_rp = 0; m_inpkt = 0; m_fwd = 0; m_rid = 0;
      m_air_v = 0; m_noc_v = 0; m_err = 0; m_lv = 0; m_q = 0;
      foreach (m_map[i]) m_map[i] = 0;
    end else begin
      eff  = (beacon_period == 0) ? DP : int'(beacon_period);
      tick = (m_cnt >= eff - 1);
      m_cnt = tick ? 0 : m_cnt + 1;
      m_q = m_map[query_id];
      rdy = m_inpkt || (!m_bp && !m_rp);
      // receive side, using state from before this edge
      m_noc_v = 0; m_err = 0; m_lv = 0; rq = 0; mk = 0;
      ty = air_rx_flit[31:30]; snd = air_rx_flit[27:20]; dsys = air_rx_flit[29:22];
      if (air_rx_valid) begin
        if (ty == 2'b11) begin
          kn = m_map[snd];
          if (air_rx_flit[29:28] == 2'b00 && snd != OWN && !kn && !m_rp) begin
            mk = 1; mk_id = snd; rq = 1; rq_id = snd;
          end
          if (air_rx_flit[29:28] == 2'b01 && air_rx_flit[19:12] == OWN && snd != OWN) begin
            if (!kn) begin mk = 1; mk_id = snd; end
            m_lv = 1; m_lid = snd; m_lres = air_rx_flit[11:0];
          end
        end else if (ty == 2'b10) begin
          if (dsys == OWN) begin m_fwd = 1; m_noc_v = 1; m_noc_f = air_rx_flit; end
          else begin m_fwd = 0; m_err = !m_map[dsys]; end
        end else begin
          if (m_fwd) begin m_noc_v = 1; m_noc_f = air_rx_flit; end
          if (ty == 2'b01) m_fwd = 0;
        end
      end
      // transmit side
      m_air_v = 0;
      if (tx_in_valid && rdy) begin
        m_air_v = 1; m_air_f = tx_in_flit;
        if (tx_in_flit[31:30] == 2'b10) m_inpkt = 1;
        else if (tx_in_flit[31:30] == 2'b01) m_inpkt = 0;
      end else if (!m_inpkt && m_bp) begin
        m_air_v = 1; m_air_f = {2'b11, 2'b00, OWN, 8'h00, RES}; m_bp = 0;
      end else if (!m_inpkt && m_rp) begin
        m_air_v = 1; m_air_f = {2'b11, 2'b01, OWN, m_rid, RES}; m_rp = 0;
      end
      if (tick) m_bp = 1;
      if (rq) begin m_rp = 1; m_rid = rq_id; end
      if (mk) m_map[mk_id] = 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    chk("R4 tx_in_ready", 32'(tx_in_ready), 32'(m_inpkt || (!m_bp && !m_rp)));
    chk("R2 R3 R4 R8 air_tx_valid", 32'(air_tx_valid), 32'(m_air_v));
    if (m_air_v) chk("R2 R3 R8 air_tx_flit", air_tx_flit, m_air_f);
    chk("R5 R6 noc_out_valid", 32'(noc_out_valid), 32'(m_noc_v));
    if (m_noc_v) chk("R5 noc_out_flit", noc_out_flit, m_noc_f);
    chk("R7 unknown_dst_err", 32'(unknown_dst_err), 32'(m_err));
    chk("R10 peer_learn_valid", 32'(peer_learn_valid), 32'(m_lv));
    if (m_lv) chk("R10 peer_learn", {12'h0, peer_learn_id, peer_learn_res}, {12'h0, m_lid, m_lres});
    chk("R9 R11 R12 query_present", 32'(query_present), 32'(m_q));
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] hd(input logic [7:0] ds);
    return {2'b10, ds, 7'd3, OWN, 7'd1};
  endfunction
  function automatic logic [31:0] bc(input logic [7:0] s);
    return {2'b11, 2'b00, s, 8'h00, 12'h111};
  endfunction
  function automatic logic [31:0] xc(input logic [7:0] s, input logic [7:0] t);
    return {2'b11, 2'b01, s, t, 12'h3C7};
  endfunction

  task automatic rx(input logic [31:0] f);
    @(negedge clk); air_rx_valid = 1'b1; air_rx_flit = f;
  endtask
  task automatic rx_stop();
    @(negedge clk); air_rx_valid = 1'b0;
  endtask
  task automatic tx(input logic [31:0] f);
    @(negedge clk); tx_in_valid = 1'b1; tx_in_flit = f;
    while (!tx_in_ready) @(negedge clk);
  endtask
  task automatic tx_stop();
    @(negedge clk); tx_in_valid = 1'b0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic query(input logic [7:0] id, input bit exp, input string tag);
    @(negedge clk); query_id = id;
    @(negedge clk); chk(tag, 32'(query_present), 32'(exp));
  endtask

  function automatic logic [7:0] pick();
    case ($urandom % 6)
      0: return OWN;
      1: return 8'h33;
      2: return 8'h50;
      3: return 8'h51;
      4: return 8'h52;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready during reset", 32'(tx_in_ready), 32'd1);
    chk("R1 air idle during reset", 32'(air_tx_valid), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 noc idle after reset", 32'(noc_out_valid), 32'd0);
    query(8'h33, 1'b0, "R1 R12 empty bitmap");
    // R2 outgoing packet
    tx(hd(8'h22)); tx({2'b00, 30'h1234}); tx({2'b01, 30'h0BEEF}); tx_stop();
    // R5 own packet, R6 R7 foreign unknown
    rx(hd(OWN)); rx({2'b00, 30'h77}); rx({2'b01, 30'h78});
    rx(hd(8'h33)); rx({2'b00, 30'h9}); rx({2'b01, 30'hA}); rx_stop();
    // R8 new beacon
    rx(bc(8'h33)); rx_stop(); idle(3);
    query(8'h33, 1'b1, "R8 newcomer marked");
    rx(hd(8'h33)); rx({2'b01, 30'h1}); rx_stop();
    // R9 known and own beacons
    rx(bc(8'h33)); rx(bc(OWN)); rx_stop(); idle(3);
    query(OWN, 1'b0, "R9 own beacon ignored");
    // R4 R11 replies and beacons deferred behind a long packet
    fork
      begin
        tx(hd(8'h60));
        for (int i = 0; i < 30; i++) tx({2'b00, 30'(i)});
        tx({2'b01, 30'h5}); tx_stop();
      end
      begin
        idle(4); rx(bc(8'h40)); rx(bc(8'h41)); rx_stop();
      end
    join
    idle(10);
    query(8'h41, 1'b0, "R11 second newcomer left unmarked");
    rx(bc(8'h41)); rx_stop(); idle(4);
    query(8'h41, 1'b1, "R11 picked up at next beacon");
    // R10 exchange frames
    rx(xc(8'h70, OWN)); rx(xc(8'h71, 8'h06)); rx_stop(); idle(2);
    query(8'h70, 1'b1, "R10 exchange sender marked");
    query(8'h71, 1'b0, "R10 foreign exchange ignored");
    // R3 programmed period
    @(negedge clk); beacon_period = 8'd25;
    idle(80);
    // random mix
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      tx_in_valid = 1'($urandom);
      case ($urandom % 3)
        0: tx_in_flit = hd(pick());
        1: tx_in_flit = {2'b00, 30'($urandom)};
        default: tx_in_flit = {2'b01, 30'($urandom)};
      endcase
      air_rx_valid = 1'($urandom);
      case ($urandom % 5)
        0: air_rx_flit = hd(pick());
        1: air_rx_flit = {2'b00, 30'($urandom)};
        2: air_rx_flit = {2'b01, 30'($urandom)};
        3: air_rx_flit = bc(pick());
        default: air_rx_flit = {2'b11, 2'($urandom), pick(), pick(), 12'($urandom)};
      endcase
      query_id = pick();
      if (c == 2000) beacon_period = 8'd0;
    end
    @(negedge clk); tx_in_valid = 1'b0; air_rx_valid = 1'b0;
    idle(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule